// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block drives the system reset line from two causes. The first is a digital undervoltage flag from an external comparator, which is high while the supply sits below its trip level. The second is an active-low manual reset pin, which the block assumes is already synchronised to its clock. Each cause passes through its own glitch filter. A filter changes its output only after its input has held the new level for a set number of clock cycles. This rejects short spikes in either direction.

While either filtered cause is active, the reset line is asserted. Once both causes have cleared, one shared hold timer keeps reset asserted for a fixed period. Any valid cause that appears during that period reloads the timer, so the full period is always measured from the last cause to clear.

The hold period is set in milliseconds against the clock rate in kHz, so the minimum holds for any configured clock. The polarity of the output line is chosen by a parameter. A synchronous reset forces the block into the asserted state, and a full filter and hold sequence must then run before the first release.

Top module: `supply_reset_gen`

## Requirements
- R1: A low level on `mr_n` that is sampled on MR_FILT_CYC consecutive rising edges asserts reset. The output changes one cycle after the last of those edges, which is MR_FILT_CYC+1 edges after the pin went low.
- R2: A low pulse on `mr_n` lasting fewer than MR_FILT_CYC cycles leaves the reset output unchanged.
- R3: A high level on `uv_flag` that is sampled on UV_FILT_CYC consecutive edges asserts reset, with the output changing UV_FILT_CYC+1 edges after the flag rose.
- R4: A high pulse on `uv_flag` lasting fewer than UV_FILT_CYC cycles leaves the reset output unchanged.
- R5: Reset stays asserted for as long as either filtered cause is active, including while the two causes overlap in any order.
- R6: Let HOLD = CLK_KHZ*HOLD_MS. Reset is released exactly HOLD+1 cycles after the last filtered cause clears. The filtered cause itself clears one filter length after its input returns to the idle level.
- R7: A valid cause that is recognised during the hold period reloads the full period. A glitch shorter than its filter length during the hold period does not move the release.
- R8: While `rst_n` is low, reset is asserted. After `rst_n` rises, the first release needs both filters to see idle levels for their full lengths, followed by the full hold period.
- R9: With ACTIVE_HIGH=1 an asserted reset drives `sys_rst` high. With ACTIVE_HIGH=0 it drives `sys_rst` low. The timing is identical in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset; forces the asserted state |
| uv_flag | input | 1 | Undervoltage flag from the comparator, 1 = supply low |
| mr_n | input | 1 | Manual reset pin, active low, already synchronised |
| sys_rst | output | 1 | System reset line; polarity set by ACTIVE_HIGH |

## Verification
The bench aims at each filter's length boundary. It drives pulses one cycle short of the filter length and pulses of exactly the filter length. An off-by-one filter would either let the short pulse through or miss the exact one. The bench checks the release on the exact cycle, so a timer that is one cycle short, or that counts from the raw input instead of the filtered cause, shows up as an early or late edge. A supply dip during the hold period must push the release out. A manual-pin glitch during the hold period must not move it. A timer that ignores reloads, or that reloads on raw glitches, fails one of these two cases. Both overlap orders and both output polarities are checked on the same stimulus.

// File: rtl/supv_pkg.sv
// Shared helpers for the supply supervisor reset generator.
// Assumes: counts passed in are non-negative.
package supv_pkg;

    // Number of bits needed to hold values 0..n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/level_filter.sv
// Saturating-counter glitch filter. The output takes the input's level only
// after the input has differed from the output on FILT_CYC consecutive edges.
// Assumes: din is synchronous to clk; FILT_CYC >= 1.
module level_filter #(
    parameter int FILT_CYC = 4,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    import supv_pkg::*;

    localparam int CW = cnt_width(FILT_CYC);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt;

    // Count cycles of disagreement; adopt the new level when the count saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= RST_VAL;
            cnt  <= '0;
        end else if (din == dout) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            dout <= din;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(din) == dout)); // R2 R4

    AST_FILT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (din != dout && cnt != LAST) |=> (dout == $past(dout))); // R4

endmodule

// File: rtl/hold_timer.sv
// Post-release hold timer. Reloads on any active cause, counts down once the
// cause clears, and keeps 'active' high until the count is exhausted.
// Assumes: cause is a registered, already filtered signal; HOLD_CYC >= 1.
module hold_timer #(
    parameter int HOLD_CYC = 1400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic active
);
    import supv_pkg::*;

    localparam int HW = cnt_width(HOLD_CYC);
    localparam logic [HW-1:0] FULL = HW'(HOLD_CYC);

    logic [HW-1:0] cnt;

    // Reload while a cause is present, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else if (cause) begin
            cnt <= FULL;
        end else if (cnt != '0) begin
            cnt <= cnt - HW'(1);
        end
    end

    // Registered reset request: a live cause or a running hold count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
        end else begin
            active <= cause | (cnt != '0);
        end
    end

    AST_RELOAD_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (cnt == FULL)); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && cnt != '0) |=> (cnt == $past(cnt) - HW'(1))); // R6

    AST_HOLD_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && cnt != '0) |=> active); // R6

endmodule

// File: rtl/supply_reset_gen.sv
// Supply supervisor reset generator. Filters the manual reset pin and the
// undervoltage flag separately, merges them into one cause, and stretches
// the release through a shared hold timer. Output polarity is chosen by
// ACTIVE_HIGH.
// Assumes: mr_n is synchronised; uv_flag is high while the supply is low.
module supply_reset_gen #(
    parameter int CLK_KHZ     = 10000,
    parameter int HOLD_MS     = 140,
    parameter int MR_FILT_CYC = 16,
    parameter int UV_FILT_CYC = 100,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    input  logic mr_n,
    output logic sys_rst
);
    localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;

    logic mr_q;
    logic uv_q;
    logic cause;
    logic active;

    // Manual pin filter; the reset state is "pressed".
    level_filter #(.FILT_CYC(MR_FILT_CYC), .RST_VAL(1'b0)) u_mr_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (mr_n),
        .dout (mr_q)
    );

    // Undervoltage flag filter; the reset state is "supply low".
    level_filter #(.FILT_CYC(UV_FILT_CYC), .RST_VAL(1'b1)) u_uv_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (uv_flag),
        .dout (uv_q)
    );

    // Either filtered source is a reason to hold the system in reset.
    always_comb cause = ~mr_q | uv_q;

    hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .active(active)
    );

    // Pick the output polarity.
    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign sys_rst = active;
        end else begin : g_pol_low
            assign sys_rst = ~active;
        end
    endgenerate

    AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> active); // R5

    AST_RELEASE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(mr_q) && !$past(uv_q))); // R6

endmodule

// File: tb/supply_reset_gen_test.sv
module supply_reset_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int FM = 4;
    localparam int FU = 6;
    localparam int KHZ = 1;
    localparam int MS = 40;
    localparam int H = KHZ * MS;

    typedef struct {
        int    at;
        bit    act;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_flag = 1'b0;
    logic mr_n = 1'b1;
    logic rst_hi;
    logic rst_lo;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    supply_reset_gen #(.CLK_KHZ(KHZ), .HOLD_MS(MS), .MR_FILT_CYC(FM),
                       .UV_FILT_CYC(FU), .ACTIVE_HIGH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .mr_n(mr_n), .sys_rst(rst_hi));

    supply_reset_gen #(.CLK_KHZ(KHZ), .HOLD_MS(MS), .MR_FILT_CYC(FM),
                       .UV_FILT_CYC(FU), .ACTIVE_HIGH(1'b0)) uut_low (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .mr_n(mr_n), .sys_rst(rst_lo));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input bit act, input string tag);
        exp_t e;
        e.at = at; e.act = act; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare both polarities against items due in this cycle.
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].at == cyc) begin
                checks++;
                if (rst_hi !== exp_q[i].act) begin
                    errors++;
                    $display("FAIL %s cycle %0d high-polarity: actual %b expected %b",
                             exp_q[i].tag, cyc, rst_hi, exp_q[i].act);
                end
                checks++;
                if (rst_lo !== !exp_q[i].act) begin
                    errors++;
                    $display("FAIL R9/%s cycle %0d low-polarity: actual %b expected %b",
                             exp_q[i].tag, cyc, rst_lo, !exp_q[i].act);
                end
                exp_q.delete(i);
            end else if (exp_q[i].at < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s missed cycle %0d: actual none expected %b",
                         exp_q[i].tag, exp_q[i].at, exp_q[i].act);
                exp_q.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        int c2;
        int c3;
        int c4;
        // R8: reset state and first release
        expect_at(2, 1'b1, "R8");
        step(3);
        rst_n = 1'b1;
        c = cyc;
        expect_at(c + FM + 1, 1'b1, "R8");
        expect_at(c + FU + H, 1'b1, "R8");
        expect_at(c + FU + H + 1, 1'b0, "R8");
        step(FU + H + 5);

        // R2: manual glitch one cycle short of the filter
        c = cyc; mr_n = 1'b0;
        expect_at(c + FM + 1, 1'b0, "R2");
        expect_at(c + FM + 3, 1'b0, "R2");
        step(FM - 1); mr_n = 1'b1;
        step(10);

        // R1: press of exactly the filter length
        c = cyc; mr_n = 1'b0;
        expect_at(c + FM, 1'b0, "R1");
        expect_at(c + FM + 1, 1'b1, "R1");
        step(FM); mr_n = 1'b1; c2 = cyc;
        expect_at(c2 + FM + H, 1'b1, "R6");
        expect_at(c2 + FM + H + 1, 1'b0, "R6");
        step(FM + H + 5);

        // R5: long press holds reset throughout
        c = cyc; mr_n = 1'b0;
        expect_at(c + FM + 1, 1'b1, "R1");
        expect_at(c + 25, 1'b1, "R5");
        step(30); mr_n = 1'b1; c2 = cyc;
        expect_at(c2 + FM + H, 1'b1, "R6");
        expect_at(c2 + FM + H + 1, 1'b0, "R6");
        step(FM + H + 5);

        // R4: supply dip shorter than its filter
        c = cyc; uv_flag = 1'b1;
        expect_at(c + FU + 1, 1'b0, "R4");
        expect_at(c + FU + 4, 1'b0, "R4");
        step(FU - 1); uv_flag = 1'b0;
        step(12);

        // R3: sustained undervoltage
        c = cyc; uv_flag = 1'b1;
        expect_at(c + FU, 1'b0, "R3");
        expect_at(c + FU + 1, 1'b1, "R3");
        step(12); uv_flag = 1'b0; c2 = cyc;
        expect_at(c2 + FU + H, 1'b1, "R6");
        expect_at(c2 + FU + H + 1, 1'b0, "R6");
        step(FU + H + 5);

        // R7: manual glitch during hold does not move the release
        mr_n = 1'b0; step(8); mr_n = 1'b1; c2 = cyc;
        expect_at(c2 + FM + H, 1'b1, "R7");
        expect_at(c2 + FM + H + 1, 1'b0, "R7");
        step(20); mr_n = 1'b0; step(FM - 1); mr_n = 1'b1;
        step(FM + H + 5);

        // R7: supply dip during hold restarts the full period
        mr_n = 1'b0; step(8); mr_n = 1'b1; c2 = cyc;
        step(20); uv_flag = 1'b1; c3 = cyc;
        expect_at(c3 + 3, 1'b1, "R7");
        expect_at(c2 + FM + H + 1, 1'b1, "R7");
        step(8); uv_flag = 1'b0; c4 = cyc;
        expect_at(c4 + FU + H, 1'b1, "R7");
        expect_at(c4 + FU + H + 1, 1'b0, "R7");
        step(FU + H + 5);

        // R5: overlap, supply first and manual last to clear
        c = cyc; uv_flag = 1'b1;
        step(3); mr_n = 1'b0;
        step(7); uv_flag = 1'b0;
        expect_at(c + 18, 1'b1, "R5");
        step(10); mr_n = 1'b1; c2 = cyc;
        expect_at(c2 + FM + H, 1'b1, "R5");
        expect_at(c2 + FM + H + 1, 1'b0, "R6");
        step(FM + H + 5);

        // R5: overlap, manual first and supply last to clear
        c = cyc; mr_n = 1'b0;
        step(2); uv_flag = 1'b1;
        step(6); mr_n = 1'b1;
        expect_at(c + 14, 1'b1, "R5");
        step(7); uv_flag = 1'b0; c2 = cyc;
        expect_at(c2 + FU + H, 1'b1, "R5");
        expect_at(c2 + FU + H + 1, 1'b0, "R6");
        step(FU + H + 5);

        // R8: reset mid-operation reasserts immediately
        rst_n = 1'b0; c = cyc;
        expect_at(c + 2, 1'b1, "R8");
        step(3); rst_n = 1'b1; c2 = cyc;
        expect_at(c2 + FU + H, 1'b1, "R8");
        expect_at(c2 + FU + H + 1, 1'b0, "R8");
        step(FU + H + 5);

        while (exp_q.size() > 0) step(1);
        finish_run();
    end
endmodule